// File: doc/BRIEF.md
# Free-Running Pipeline Cluster with Exit Queue

The block is a fixed-latency pipeline of `STAGES` registers that never stall. Every stage moves forward on every clock edge, whatever the consumer is doing. A queue at the pipeline's end catches each valid result. Empty slots (bubbles) are dropped before they reach the queue, so results that pile up behind a consumer stall are packed with no gaps. The producer sees a single stall output. That output depends only on how full the queue is and on how many valid items are still travelling through the stages. No stall signal is routed to the stage registers.

The producer side is a valid/data pair plus the stall output. An item is taken in any cycle where its valid is high and the stall is low. The consumer side shows the queue head as a valid/data pair. The consumer pops the head in any cycle where that valid is high and the consumer's stall input is low. A build-time parameter picks one of two queue styles. The registered style adds one cycle between write and read. The fall-through style shows a result at the output in the same cycle it leaves the last stage, provided the queue is empty. Each stage adds its own constant to the data; this is a placeholder for real arithmetic.

Top module: `free_run_cluster`

## Requirements
- R1: After reset, `outValid` and `inStall` are both low, the queue is empty and no stage holds a valid item.
- R2: Stage registers advance every clock regardless of `outStall`. An item accepted while the pipeline and queue are empty reaches `outValid` exactly `STAGES+1` cycles later with the registered queue, even if `outStall` is held high.
- R3: No accepted item is ever lost or overwritten. `FIFO_DEPTH` must be at least `STAGES`, and every accepted item is eventually delivered once the consumer drains.
- R4: Only valid stage outputs are written to the queue. After a consumer stall, the stored items leave on consecutive cycles with no gaps between them.
- R5: `inStall` is high exactly when the queue count plus the number of valid items in the stages is at least `FIFO_DEPTH`. An input offered while `inStall` is high is not taken. With the queue empty and the consumer stalled, exactly `FIFO_DEPTH` back-to-back inputs are taken.
- R6: `outData` equals the accepted input plus `STAGES*(STAGES+1)/2`, modulo 2^`DATA_W` (stage k, counting from 1, adds k).
- R7: Items leave in the order they were accepted.
- R8: With `FALL_THROUGH=1`, an item entering an empty queue appears at the output `STAGES` cycles after it was accepted, which is the same cycle it leaves the last stage.
- R9: While `outValid` is high and `outStall` is high, the next cycle still shows `outValid` high with unchanged `outData`.
- R10: The in-flight count can rise and fall in the same cycle. With `FIFO_DEPTH >= STAGES+2`, a registered queue and a consumer that never stalls, a continuous input stream is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Producer offers an item |
| inData | input | DATA_W | Producer item |
| inStall | output | 1 | Producer must hold; input not taken |
| outValid | output | 1 | Queue head is available |
| outData | output | DATA_W | Queue head value |
| outStall | input | 1 | Consumer refuses the head this cycle |

## Verification
The assertions assume the producer treats `inStall` as authoritative: an item offered while the stall is high counts as not taken and must be offered again. They also assume `outStall` is a clean level sampled at the clock edge. Neither input is assumed to be stable or held. The random stimulus drives valid, data and consumer stall independently every cycle from a seeded generator. Directed sequences add bubble patterns under a long stall, a fill from empty, and full-rate streaming, which all stay within those assumptions.

// File: rtl/frc_pkg.sv
package frc_pkg;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic accept;   // a new item enters stage 0
    logic wrEn;     // last-stage item is stored in the queue
    logic bypass;   // output mux takes the last stage directly
  } frcStrobes_t;

endpackage

// File: rtl/frc_datapath.sv
module frc_datapath
  import frc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int STAGES     = 4,
  parameter int FIFO_DEPTH = 6,
  localparam int PTR_W     = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  frcStrobes_t       strobes,
  input  logic [PTR_W-1:0]  wrAddr,
  input  logic [PTR_W-1:0]  rdAddr,
  output logic              lastValid,
  output logic [STAGES-1:0] validVec,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0] stageData [STAGES];
  logic [DATA_W-1:0] store [FIFO_DEPTH];

  // Free-running stages: no enable, no stall
  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) validVec[0] <= 1'b0;
          else       validVec[0] <= strobes.accept;
        end
        always_ff @(posedge clk) begin
          stageData[0] <= inData + DATA_W'(1);
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) validVec[k] <= 1'b0;
          else       validVec[k] <= validVec[k-1];
        end
        always_ff @(posedge clk) begin
          stageData[k] <= stageData[k-1] + DATA_W'(k + 1);
        end
      end
    end
  endgenerate

  assign lastValid = validVec[STAGES-1];

  // Queue storage
  always_ff @(posedge clk) begin
    if (strobes.wrEn) store[wrAddr] <= stageData[STAGES-1];
  end

  assign outData = strobes.bypass ? stageData[STAGES-1] : store[rdAddr];

endmodule

// File: rtl/frc_control.sv
module frc_control
  import frc_pkg::*;
#(
  parameter int STAGES       = 4,
  parameter int FIFO_DEPTH   = 6,
  parameter bit FALL_THROUGH = 1'b0,
  localparam int PTR_W       = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
  localparam int CNT_W       = $clog2(FIFO_DEPTH + 1),
  localparam int FL_W        = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inStall,
  input  logic              outStall,
  input  logic              lastValid,
  output logic              outValid,
  output frcStrobes_t       strobes,
  output logic [PTR_W-1:0]  wrAddr,
  output logic [PTR_W-1:0]  rdAddr,
  output logic [FL_W-1:0]   inFlight
);

  localparam int SUM_W = ((CNT_W > FL_W) ? CNT_W : FL_W) + 1;

  logic [CNT_W-1:0] count;
  logic [SUM_W-1:0] occupancy;
  logic             queueEmpty;
  logic             useBypass;
  logic             pop;
  logic             rdAdv;

  assign queueEmpty = (count == '0);
  assign occupancy  = SUM_W'(count) + SUM_W'(inFlight);
  assign inStall    = (occupancy >= SUM_W'(FIFO_DEPTH));

  generate
    if (FALL_THROUGH) begin : g_ft
      assign useBypass = queueEmpty;
      assign outValid  = !queueEmpty || lastValid;
    end else begin : g_reg
      assign useBypass = 1'b0;
      assign outValid  = !queueEmpty;
    end
  endgenerate

  assign pop            = outValid && !outStall;
  assign rdAdv          = pop && !useBypass;
  assign strobes.accept = inValid && !inStall;
  assign strobes.wrEn   = lastValid && !(useBypass && pop);
  assign strobes.bypass = useBypass;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      inFlight <= '0;
      wrAddr   <= '0;
      rdAddr   <= '0;
    end else begin
      count    <= count + CNT_W'(strobes.wrEn) - CNT_W'(rdAdv);
      inFlight <= inFlight + FL_W'(strobes.accept) - FL_W'(lastValid);
      if (strobes.wrEn)
        wrAddr <= (wrAddr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrAddr + PTR_W'(1);
      if (rdAdv)
        rdAddr <= (rdAddr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdAddr + PTR_W'(1);
    end
  end

  // R3: an arriving item always finds a free slot
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    lastValid |-> (count < CNT_W'(FIFO_DEPTH)));

  // R5: stored plus travelling items never exceed the queue size
  a_r5_occupancy_bound: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= SUM_W'(FIFO_DEPTH));

endmodule

// File: rtl/free_run_cluster.sv
module free_run_cluster
  import frc_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int STAGES       = 4,
  parameter int FIFO_DEPTH   = 6,
  parameter bit FALL_THROUGH = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inStall,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outStall
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int FL_W  = $clog2(STAGES + 1);

  generate
    if (FIFO_DEPTH < STAGES) begin : g_bad_depth
      $error("FIFO_DEPTH must cover the pipeline latency");
    end
  endgenerate

  frcStrobes_t       strobes;
  logic [PTR_W-1:0]  wrAddr;
  logic [PTR_W-1:0]  rdAddr;
  logic              lastValid;
  logic [STAGES-1:0] validVec;
  logic [FL_W-1:0]   inFlight;

  frc_control #(
    .STAGES(STAGES), .FIFO_DEPTH(FIFO_DEPTH), .FALL_THROUGH(FALL_THROUGH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStall(inStall),
    .outStall(outStall), .lastValid(lastValid), .outValid(outValid),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr), .inFlight(inFlight)
  );

  frc_datapath #(
    .DATA_W(DATA_W), .STAGES(STAGES), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .lastValid(lastValid),
    .validVec(validVec), .outData(outData)
  );

  // R9: a refused head is held unchanged
  a_r9_hold_head: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStall) |=> (outValid && $stable(outData)));

  // R10: the control counter tracks the valid bits in the stages
  a_r10_inflight_match: assert property (@(posedge clk) disable iff (!rstN)
    FL_W'($countones(validVec)) == inFlight);

  // R1: nothing visible right after reset
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && !inStall));

endmodule

// File: tb/free_run_cluster_tb.sv
`timescale 1ns/1ps
module free_run_cluster_tb;

  localparam int W     = 16;
  localparam int N     = 4;
  localparam int DEPTH = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic         aInValid = 0, aOutStall = 0, aInStall, aOutValid;
  logic [W-1:0] aInData = '0, aOutData;
  logic         bInValid = 0, bOutStall = 0, bInStall, bOutValid;
  logic [W-1:0] bInData = '0, bOutData;

  free_run_cluster #(.DATA_W(W), .STAGES(N), .FIFO_DEPTH(DEPTH), .FALL_THROUGH(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(aInValid), .inData(aInData), .inStall(aInStall),
    .outValid(aOutValid), .outData(aOutData), .outStall(aOutStall));

  free_run_cluster #(.DATA_W(W), .STAGES(N), .FIFO_DEPTH(DEPTH), .FALL_THROUGH(1'b1)) u_dutFt (
    .clk(clk), .rstN(rstN), .inValid(bInValid), .inData(bInData), .inStall(bInStall),
    .outValid(bOutValid), .outData(bOutData), .outStall(bOutStall));

  int checks = 0;
  int fails  = 0;

  // Bench model state, per DUT (0 registered, 1 fall-through)
  bit           mv [2][N];
  int           mcount [2];
  logic [W-1:0] qa [$];
  logic [W-1:0] qb [$];
  bit           prevHold [2];
  logic [W-1:0] prevData [2];
  bit           lastV, lastAccept, lastStall;

  function automatic logic [W-1:0] xform(logic [W-1:0] d);
    return d + W'(N * (N + 1) / 2);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic step(bit sel, bit v, logic [W-1:0] d, bit s);
    bit oV, iS, pop, acc, expOV;
    logic [W-1:0] oD, front;
    int ones;
    @(negedge clk);
    oV = sel ? bOutValid : aOutValid;
    oD = sel ? bOutData  : aOutData;
    iS = sel ? bInStall  : aInStall;
    ones = 0;
    for (int k = 0; k < N; k++) ones += int'(mv[sel][k]);
    chk(iS == ((mcount[sel] + ones) >= DEPTH), "R5 stall from occupancy", iS, (mcount[sel] + ones) >= DEPTH);
    expOV = (mcount[sel] != 0) || (sel && mv[sel][N-1]);
    chk(oV == expOV, sel ? "R8 output valid timing" : "R2 output valid timing", oV, expOV);
    if (prevHold[sel]) chk(oV && oD == prevData[sel], "R9 head held", oD, prevData[sel]);
    pop = oV && !s;
    if (pop) begin
      if (sel ? (qb.size() == 0) : (qa.size() == 0)) begin
        chk(1'b0, "R3 unexpected item", oD, 0);
      end else begin
        front = sel ? qb.pop_front() : qa.pop_front();
        chk(oD == front, "R6 R7 data and order", oD, front);
      end
    end
    if (sel) begin bInValid = v; bInData = d; bOutStall = s; end
    else     begin aInValid = v; aInData = d; aOutStall = s; end
    acc = v && !iS;
    if (acc) begin
      if (sel) qb.push_back(xform(d)); else qa.push_back(xform(d));
    end
    mcount[sel] = mcount[sel] + int'(mv[sel][N-1]) - int'(pop);
    for (int k = N - 1; k > 0; k--) mv[sel][k] = mv[sel][k-1];
    mv[sel][0] = acc;
    prevHold[sel] = oV && s;
    prevData[sel] = oD;
    lastV = oV; lastAccept = acc; lastStall = iS;
  endtask

  task automatic drain(bit sel);
    for (int i = 0; i < N + DEPTH + 4; i++) step(sel, 1'b0, '0, 1'b0);
    chk((sel ? qb.size() : qa.size()) == 0, "R3 all items delivered",
        sel ? qb.size() : qa.size(), 0);
  endtask

  task automatic latency(bit sel, bit s, int exp);
    int j = 0;
    step(sel, 1'b1, 16'h1234, s);
    do begin
      step(sel, 1'b0, '0, s);
      j++;
    end while (!lastV && j < 20);
    chk(j == exp, sel ? "R8 fall-through latency" : "R2 latency under stall", j, exp);
    drain(sel);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int cnt;
    void'($urandom(32'h5eed_c1a5));
    for (int s = 0; s < 2; s++) begin
      mcount[s] = 0; prevHold[s] = 0; prevData[s] = '0;
      for (int k = 0; k < N; k++) mv[s][k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(!aOutValid && !aInStall, "R1 reset idle registered", {aOutValid, aInStall}, 0);
    chk(!bOutValid && !bInStall, "R1 reset idle fall-through", {bOutValid, bInStall}, 0);

    // R2 latency, free-running even under consumer stall
    latency(1'b0, 1'b0, N + 1);
    latency(1'b0, 1'b1, N + 1);
    // R8 fall-through latency
    latency(1'b1, 1'b0, N);

    // R4 bubbles squeezed out under stall
    step(0, 1, 16'h0011, 1); step(0, 0, '0, 1); step(0, 1, 16'h0022, 1);
    step(0, 0, '0, 1); step(0, 0, '0, 1); step(0, 1, 16'h0033, 1);
    for (int i = 0; i < N + 2; i++) step(0, 0, '0, 1);
    cnt = 0;
    do begin
      step(0, 0, '0, 0);
      if (lastV) cnt++;
    end while (lastV && cnt < 10);
    chk(cnt == 3, "R4 packed burst after stall", cnt, 3);
    drain(0);

    // R5 intake from empty while consumer stalled
    cnt = 0;
    for (int i = 0; i < DEPTH + N + 4; i++) begin
      step(0, 1, W'(i * 7), 1);
      if (lastAccept) cnt++;
    end
    chk(cnt == DEPTH, "R5 intake equals depth", cnt, DEPTH);
    chk(lastStall, "R5 stalled when full", lastStall, 1);
    drain(0);

    // R10 full-rate stream, never stalled
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      step(0, 1, W'(i), 0);
      if (i >= 10 && lastStall) cnt++;
    end
    chk(cnt == 0, "R10 no stall at full rate", cnt, 0);
    drain(0);

    // Random traffic on both queue styles
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 3000; i++)
        step(s[0], ($urandom % 4) != 0, W'($urandom), ($urandom % 3) == 0);
      drain(s[0]);
    end

    summary();
  end

endmodule